// File: doc/BRIEF.md
# Receive Descriptor Fill Engine

The engine takes received frames one byte at a time and writes them into a ring of receive descriptors held in shared memory. Each descriptor is two 32-bit words. The first word holds the status flags and the length. The second word holds the byte address of that descriptor's data buffer. A frame fills as many buffers as it needs. Each buffer takes at most a programmable number of bytes. A 4-byte CRC32 follows the payload, and the CRC is computed inside the engine while the bytes stream in.

When a descriptor is full, or the frame is complete, the engine writes the first word back. The write-back clears the empty bit, keeps the wrap bit and records the byte count. The last descriptor of a frame also receives the last flag and any length error flags. The ring pointer then moves to the next descriptor, or back to the ring base if the wrap bit was set. Frames longer than the truncation limit are shortened. A configurable two-byte zero pad can be placed at the start of the first buffer so that the payload lands on a 4-byte boundary.

A receive-active flag reports whether the descriptor under the ring pointer is empty. The flag is refreshed from memory after every frame, and also when software requests it with a kick pulse. A frame that arrives while the flag is low is consumed and discarded.

Top module: `rxfill_engine`

## Requirements
- R1: After reset, `rxActive`, `frmReady`, `memEn` and all three event outputs are low, and the ring pointer sits at the ring base rounded down to 8 bytes.
- R2: A `rxKick` pulse while idle reads word 0 of the descriptor under the ring pointer and sets `rxActive` to its bit 31 (empty).
- R3: A frame that starts while `rxActive` is low is accepted and discarded, with no memory access and no event.
- R4: The stored bytes are the optional pad, then the payload in arrival order, then the CRC32. The CRC is reflected with polynomial 0xEDB88320 and initial value all ones, and is taken over the whole received payload. Its bitwise inverse is stored most significant byte first.
- R5: No buffer receives more than `maxBufLen` bytes. The byte stream, including the CRC, continues at offset 0 of the next descriptor's buffer, so the CRC may be split across two descriptors. Word 0 bits 15:0 hold the byte count of that buffer.
- R6: Each filled descriptor has word 0 rewritten as follows: bit 31 (empty) cleared, bit 29 (wrap) kept, and bit 27 (last) set only on the final descriptor of the frame. A non-final descriptor pulses `evtRxBuf`. The final descriptor pulses `evtRxFrame`.
- R7: After a descriptor is written back, the pointer moves 8 bytes forward, or to the ring base if the wrap bit was set.
- R8: If pad + payload + 4 exceeds `truncLimit`, payload bytes beyond `truncLimit` - 4 - pad are dropped. The final descriptor then gets bit 16 (truncated) and bit 21 (too long). `truncLimit` is at least 8.
- R9: If the stored size (pad + stored payload + 4) exceeds `lenLimit`, bit 21 alone is set on the final descriptor. Otherwise neither bit 21 nor bit 16 is set.
- R10: With `shift16En` set, two zero bytes open the first buffer of the frame only, and they count in that buffer's length.
- R11: After the final write-back, `rxActive` takes the empty bit of the descriptor now under the pointer.
- R12: If a fetched descriptor is not empty, the rest of the frame is consumed and dropped, `evtOverrun` pulses, `rxActive` falls, and that descriptor is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ringBase | input | AW | Byte address of descriptor 0 of the ring |
| maxBufLen | input | LW | Largest byte count per buffer |
| truncLimit | input | LW | Largest stored frame size, including pad and CRC |
| lenLimit | input | LW | Size above which the too-long flag is set |
| shift16En | input | 1 | Insert two zero bytes before the payload |
| rxKick | input | 1 | Re-read the current descriptor's empty bit |
| frmValid | input | 1 | Frame byte valid |
| frmData | input | 8 | Frame byte |
| frmLast | input | 1 | Final byte of the frame |
| frmReady | output | 1 | Frame byte accepted when high with frmValid |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | Write when high, read otherwise |
| memAddr | output | AW | Byte address; the memory uses bits AW-1:2 |
| memBe | output | 4 | Byte lane enables for writes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, one cycle after a read request |
| rxActive | output | 1 | Receive-active flag |
| evtRxFrame | output | 1 | Pulse: frame completed |
| evtRxBuf | output | 1 | Pulse: non-final buffer closed |
| evtOverrun | output | 1 | Pulse: non-empty descriptor met mid-frame |

## Verification
Random frame lengths are run against random buffer sizes, with and without the pad. Whether a frame fits one buffer, fills buffers exactly, or leaves the CRC split over a boundary then depends on the length. This separates errors in the length field from errors in the CRC placement. Directed frames cover the remaining boundaries: one frame just over the truncation limit, one over the length limit only, one that uses all four descriptors and wraps, and one that runs into a full descriptor. Each of these tells apart a separate flag, the pointer wrap, or the overrun path. The arrival of a frame while inactive shows that discarding produces no memory traffic.

// File: rtl/rxfill_pkg.sv
package rxfill_pkg;

  localparam int BIT_EMPTY = 31;
  localparam int BIT_WRAP  = 29;
  localparam int BIT_LAST  = 27;
  localparam int BIT_LONG  = 21;
  localparam int BIT_TRUNC = 16;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;

  typedef struct packed {
    logic frameStart;
    logic rdWord0;
    logic rdWord1;
    logic capWord0;
    logic capWord1;
    logic wrPad;
    logic accPay;
    logic wrCrc;
    logic closeDesc;
    logic closeLast;
    logic advance;
  } ctrlStrobes_t;

  typedef struct packed {
    logic bufFull;
    logic padPending;
    logic crcLastByte;
    logic rdEmpty;
  } dpStatus_t;

  function automatic logic [31:0] crcStep(input logic [31:0] crcIn, input logic [7:0] dataIn);
    logic [31:0] c;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ dataIn[i]) c = (c >> 1) ^ CRC_POLY;
      else                  c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/rxfill_dpath.sv
module rxfill_dpath
  import rxfill_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] ringBase,
  input  logic [LW-1:0] maxBufLen,
  input  logic [LW-1:0] truncLimit,
  input  logic [LW-1:0] lenLimit,
  input  logic          shift16En,
  input  logic [7:0]    frmData,
  input  ctrlStrobes_t  ctl,
  output dpStatus_t     sts,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [3:0]    memBe,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata
);

  localparam logic [AW-1:0] DESC_STEP = AW'(8);
  localparam logic [AW-1:0] WORD_STEP = AW'(4);

  logic [AW-1:0] ringAligned;
  logic [AW-1:0] ptr;
  logic [AW-1:0] bufAddr;
  logic [LW-1:0] bufCnt;
  logic [LW-1:0] sizeCnt;
  logic [1:0]    padLeft;
  logic [1:0]    crcIdx;
  logic [31:0]   crcReg;
  logic          truncHit;
  logic          descWrap;

  logic          canStore;
  logic          longHit;
  logic          byteWr;
  logic [31:0]   crcShift;
  logic [7:0]    wrByte;
  logic [AW-1:0] byteAddr;
  logic          unusedBits;

  assign ringAligned = {ringBase[AW-1:3], 3'b000};
  assign canStore    = ({1'b0, sizeCnt} + (LW+1)'(5)) <= {1'b0, truncLimit};
  assign longHit     = ({1'b0, sizeCnt} + (LW+1)'(4)) > {1'b0, lenLimit};
  assign byteWr      = ctl.wrPad || ctl.wrCrc || (ctl.accPay && canStore);
  assign crcShift    = (~crcReg) << {crcIdx, 3'b000};
  assign byteAddr    = bufAddr + AW'(bufCnt);
  assign unusedBits  = ^{ringBase[2:0], memRdata[30], memRdata[28:AW]};

  always_comb begin
    if (ctl.wrCrc)      wrByte = crcShift[31:24];
    else if (ctl.wrPad) wrByte = 8'h00;
    else                wrByte = frmData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr      <= ringAligned;
      bufAddr  <= '0;
      bufCnt   <= '0;
      sizeCnt  <= '0;
      padLeft  <= '0;
      crcIdx   <= '0;
      crcReg   <= '1;
      truncHit <= 1'b0;
      descWrap <= 1'b0;
    end else begin
      if (ctl.frameStart) begin
        padLeft  <= shift16En ? 2'd2 : 2'd0;
        sizeCnt  <= '0;
        crcReg   <= '1;
        crcIdx   <= '0;
        truncHit <= 1'b0;
      end
      if (ctl.capWord0) descWrap <= memRdata[BIT_WRAP];
      if (ctl.capWord1) begin
        bufAddr <= memRdata[AW-1:0];
        bufCnt  <= '0;
      end
      if (ctl.wrPad) begin
        padLeft <= padLeft - 2'd1;
        bufCnt  <= bufCnt + 1'b1;
        sizeCnt <= sizeCnt + 1'b1;
      end
      if (ctl.accPay) begin
        crcReg <= crcStep(crcReg, frmData);
        if (canStore) begin
          bufCnt  <= bufCnt + 1'b1;
          sizeCnt <= sizeCnt + 1'b1;
        end else begin
          truncHit <= 1'b1;
        end
      end
      if (ctl.wrCrc) begin
        crcIdx <= crcIdx + 2'd1;
        bufCnt <= bufCnt + 1'b1;
      end
      if (ctl.advance) ptr <= descWrap ? ringAligned : ptr + DESC_STEP;
    end
  end

  always_comb begin
    memEn    = 1'b0;
    memWe    = 1'b0;
    memAddr  = '0;
    memBe    = '0;
    memWdata = '0;
    if (ctl.rdWord0) begin
      memEn   = 1'b1;
      memAddr = ptr;
    end else if (ctl.rdWord1) begin
      memEn   = 1'b1;
      memAddr = ptr + WORD_STEP;
    end else if (byteWr) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = byteAddr;
      memBe    = 4'b0001 << byteAddr[1:0];
      memWdata = {4{wrByte}};
    end else if (ctl.closeDesc) begin
      memEn    = 1'b1;
      memWe    = 1'b1;
      memAddr  = ptr;
      memBe    = 4'hF;
      memWdata = '0;
      memWdata[BIT_WRAP]  = descWrap;
      memWdata[BIT_LAST]  = ctl.closeLast;
      memWdata[BIT_LONG]  = ctl.closeLast && (longHit || truncHit);
      memWdata[BIT_TRUNC] = ctl.closeLast && truncHit;
      memWdata[15:0]      = 16'(bufCnt);
    end
  end

  assign sts.bufFull     = bufCnt >= maxBufLen;
  assign sts.padPending  = padLeft != 2'd0;
  assign sts.crcLastByte = crcIdx == 2'd3;
  assign sts.rdEmpty     = memRdata[BIT_EMPTY];

  // R5: a buffer byte is only written below the buffer limit
  a_r5_fill_within_buffer: assert property (@(posedge clk) disable iff (!rstN)
    byteWr |-> (bufCnt < maxBufLen));

  // R7: a pointer step always lands on an 8-byte boundary
  a_r7_ptr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> (ptr[2:0] == 3'b000));

endmodule

// File: rtl/rxfill_ctrl.sv
module rxfill_ctrl
  import rxfill_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rxKick,
  input  logic         frmValid,
  input  logic         frmLast,
  output logic         frmReady,
  input  dpStatus_t    sts,
  output ctrlStrobes_t ctl,
  output logic         rxActive,
  output logic         evtRxFrame,
  output logic         evtRxBuf,
  output logic         evtOverrun
);

  typedef enum logic [3:0] {
    S_IDLE, S_DROP, S_RDA, S_RDB, S_RDC, S_FILL, S_LAST, S_CHK, S_CHKW
  } state_t;

  state_t state, nextState;
  logic   descOk;
  logic   payDone;

  always_comb begin
    nextState  = state;
    ctl        = '0;
    frmReady   = 1'b0;
    evtRxFrame = 1'b0;
    evtRxBuf   = 1'b0;
    evtOverrun = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (rxKick) begin
          nextState = S_CHK;
        end else if (frmValid) begin
          if (rxActive) begin
            ctl.frameStart = 1'b1;
            nextState      = S_RDA;
          end else begin
            nextState = S_DROP;
          end
        end
      end
      S_DROP: begin
        frmReady = 1'b1;
        if (frmValid && frmLast) nextState = S_IDLE;
      end
      S_RDA: begin
        ctl.rdWord0 = 1'b1;
        nextState   = S_RDB;
      end
      S_RDB: begin
        ctl.rdWord1  = 1'b1;
        ctl.capWord0 = 1'b1;
        nextState    = S_RDC;
      end
      S_RDC: begin
        ctl.capWord1 = 1'b1;
        if (descOk) begin
          nextState = S_FILL;
        end else begin
          evtOverrun = 1'b1;
          nextState  = payDone ? S_IDLE : S_DROP;
        end
      end
      S_FILL: begin
        if (sts.bufFull) begin
          ctl.closeDesc = 1'b1;
          ctl.advance   = 1'b1;
          evtRxBuf      = 1'b1;
          nextState     = S_RDA;
        end else if (sts.padPending) begin
          ctl.wrPad = 1'b1;
        end else if (!payDone) begin
          frmReady   = 1'b1;
          ctl.accPay = frmValid;
        end else begin
          ctl.wrCrc = 1'b1;
          if (sts.crcLastByte) nextState = S_LAST;
        end
      end
      S_LAST: begin
        ctl.closeDesc = 1'b1;
        ctl.closeLast = 1'b1;
        ctl.advance   = 1'b1;
        evtRxFrame    = 1'b1;
        nextState     = S_CHK;
      end
      S_CHK: begin
        ctl.rdWord0 = 1'b1;
        nextState   = S_CHKW;
      end
      S_CHKW: nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      rxActive <= 1'b0;
      descOk   <= 1'b0;
      payDone  <= 1'b0;
    end else begin
      state <= nextState;
      if (state == S_RDB) descOk <= sts.rdEmpty;
      if (ctl.frameStart) payDone <= 1'b0;
      if (ctl.accPay && frmLast) payDone <= 1'b1;
      if (state == S_CHKW) rxActive <= sts.rdEmpty;
      if (evtOverrun) rxActive <= 1'b0;
    end
  end

  // R12: an overrun leaves receive inactive
  a_r12_overrun_deactivates: assert property (@(posedge clk) disable iff (!rstN)
    evtOverrun |=> !rxActive);

  // R6: a completed frame is followed by the descriptor re-check, not another close
  a_r6_frame_event_single: assert property (@(posedge clk) disable iff (!rstN)
    evtRxFrame |=> (!evtRxFrame && !evtRxBuf));

endmodule

// File: rtl/rxfill_engine.sv
module rxfill_engine
  import rxfill_pkg::*;
#(
  parameter int AW = 12,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [AW-1:0] ringBase,
  input  logic [LW-1:0] maxBufLen,
  input  logic [LW-1:0] truncLimit,
  input  logic [LW-1:0] lenLimit,
  input  logic          shift16En,
  input  logic          rxKick,
  input  logic          frmValid,
  input  logic [7:0]    frmData,
  input  logic          frmLast,
  output logic          frmReady,
  output logic          memEn,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [3:0]    memBe,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  output logic          rxActive,
  output logic          evtRxFrame,
  output logic          evtRxBuf,
  output logic          evtOverrun
);

  ctrlStrobes_t ctl;
  dpStatus_t    sts;

  rxfill_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxKick     (rxKick),
    .frmValid   (frmValid),
    .frmLast    (frmLast),
    .frmReady   (frmReady),
    .sts        (sts),
    .ctl        (ctl),
    .rxActive   (rxActive),
    .evtRxFrame (evtRxFrame),
    .evtRxBuf   (evtRxBuf),
    .evtOverrun (evtOverrun)
  );

  rxfill_dpath #(.AW(AW), .LW(LW)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .ringBase   (ringBase),
    .maxBufLen  (maxBufLen),
    .truncLimit (truncLimit),
    .lenLimit   (lenLimit),
    .shift16En  (shift16En),
    .frmData    (frmData),
    .ctl        (ctl),
    .sts        (sts),
    .memEn      (memEn),
    .memWe      (memWe),
    .memAddr    (memAddr),
    .memBe      (memBe),
    .memWdata   (memWdata),
    .memRdata   (memRdata)
  );

  // R6: the final write-back carries the last flag and clears empty
  a_r6_frame_close_last: assert property (@(posedge clk) disable iff (!rstN)
    evtRxFrame |-> (memWe && memWdata[BIT_LAST] && !memWdata[BIT_EMPTY]));

  // R6: an intermediate write-back never carries the last flag
  a_r6_buf_close_not_last: assert property (@(posedge clk) disable iff (!rstN)
    evtRxBuf |-> (memWe && !memWdata[BIT_LAST] && !memWdata[BIT_EMPTY]));

  // R3: while inactive, accepting bytes causes no memory traffic
  a_r3_inactive_no_mem: assert property (@(posedge clk) disable iff (!rstN)
    (!rxActive && frmReady) |-> !memEn);

endmodule

// File: tb/tb_rxfill_engine.sv
`timescale 1ns/1ps
module tb_rxfill_engine;

  localparam int AW = 12;
  localparam int LW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] ringBase = '0;
  logic [LW-1:0] maxBufLen = 16'd16;
  logic [LW-1:0] truncLimit = 16'd2047;
  logic [LW-1:0] lenLimit = 16'd1518;
  logic          shift16En = 1'b0;
  logic          rxKick = 1'b0;
  logic          frmValid = 1'b0;
  logic [7:0]    frmData = '0;
  logic          frmLast = 1'b0;
  logic          frmReady;
  logic          memEn, memWe;
  logic [AW-1:0] memAddr;
  logic [3:0]    memBe;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = '0;
  logic          rxActive, evtRxFrame, evtRxBuf, evtOverrun;

  logic [31:0] mem [0:1023];
  logic [7:0]  fb [0:255];
  int nChecks = 0, nFails = 0;
  int cntFrame = 0, cntBuf = 0, cntOvr = 0, cntWr = 0;

  always #2.5 clk = ~clk;

  rxfill_engine #(.AW(AW), .LW(LW)) dut (
    .clk(clk), .rstN(rstN), .ringBase(ringBase), .maxBufLen(maxBufLen),
    .truncLimit(truncLimit), .lenLimit(lenLimit), .shift16En(shift16En),
    .rxKick(rxKick), .frmValid(frmValid), .frmData(frmData), .frmLast(frmLast),
    .frmReady(frmReady), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata), .rxActive(rxActive),
    .evtRxFrame(evtRxFrame), .evtRxBuf(evtRxBuf), .evtOverrun(evtOverrun)
  );

  always @(posedge clk) begin
    if (memEn && memWe) begin
      for (int b = 0; b < 4; b++)
        if (memBe[b]) mem[memAddr[AW-1:2]][8*b +: 8] <= memWdata[8*b +: 8];
    end
    if (memEn && !memWe) memRdata <= mem[memAddr[AW-1:2]];
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (evtRxFrame) cntFrame++;
      if (evtRxBuf) cntBuf++;
      if (evtOverrun) cntOvr++;
      if (memEn && memWe) cntWr++;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    cntFrame = 0; cntBuf = 0; cntOvr = 0; cntWr = 0;
  endtask

  task automatic setupRing(input int nEmpty);
    for (int w = 0; w < 64; w++) mem[w] = 32'h0;
    for (int d = 0; d < 4; d++) begin
      mem[2*d]   = (d < nEmpty ? 32'h8000_0000 : 32'h0) | (d == 3 ? 32'h2000_0000 : 32'h0);
      mem[2*d+1] = 32'h100 + d * 32'h40;
    end
    for (int w = 64; w < 128; w++) mem[w] = 32'hEEEE_EEEE;
  endtask

  task automatic kick();
    @(negedge clk);
    rxKick = 1'b1;
    @(negedge clk);
    rxKick = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendFrame(input int len);
    for (int i = 0; i < len; i++) begin
      frmData  = fb[i];
      frmLast  = (i == len - 1);
      frmValid = 1'b1;
      while (!frmReady) @(negedge clk);
      @(negedge clk);
    end
    frmValid = 1'b0;
    frmLast  = 1'b0;
    repeat (40) @(negedge clk);
  endtask

  function automatic logic [31:0] refCrc(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'h0, fb[i]};
      for (int b = 0; b < 8; b++) c = (c >> 1) ^ (32'hEDB8_8320 & {32{c[0]}});
    end
    return ~c;
  endfunction

  function automatic logic [7:0] memByte(input int a);
    return mem[a >> 2][8*(a % 4) +: 8];
  endfunction

  task automatic runFrame(input int len, input int nEmpty);
    logic [7:0]  eb [0:511];
    logic [31:0] crc, expW;
    int pad, cap, size, nCh, filled, mb, clen, bad;
    bit trunc, long, ov;
    pad  = shift16En ? 2 : 0;
    mb   = int'(maxBufLen);
    doReset();
    setupRing(nEmpty);
    kick();
    size = 0;
    for (int i = 0; i < pad; i++) eb[size++] = 8'h00;
    cap = len;
    if (cap > int'(truncLimit) - 4 - pad) cap = int'(truncLimit) - 4 - pad;
    for (int i = 0; i < cap; i++) eb[size++] = fb[i];
    crc = refCrc(len);
    eb[size++] = crc[31:24]; eb[size++] = crc[23:16];
    eb[size++] = crc[15:8];  eb[size++] = crc[7:0];
    trunc = (len + pad + 4) > int'(truncLimit);
    long  = trunc || (size > int'(lenLimit));
    nCh   = (size + mb - 1) / mb;
    ov = 1'b0; filled = 0;
    for (int k = 0; k < nCh; k++) begin
      if (k >= 4 || k >= nEmpty) begin ov = 1'b1; break; end
      filled++;
    end
    sendFrame(len);
    for (int k = 0; k < filled; k++) begin
      clen = (size - k*mb < mb) ? size - k*mb : mb;
      expW = 32'(clen);
      if (k == 3) expW |= 32'h2000_0000;
      if (!ov && k == nCh - 1) begin
        expW |= 32'h0800_0000;
        if (long)  expW |= 32'h0020_0000;
        if (trunc) expW |= 32'h0001_0000;
      end
      // R5 R6 R8 R9: descriptor word 0 after write-back
      chk(mem[2*k] == expW, "R5/R6/R8/R9 descriptor word0", mem[2*k], expW);
      bad = 0;
      for (int j = 0; j < clen; j++)
        if (memByte(32'h100 + k*32'h40 + j) != eb[k*mb + j]) bad++;
      if (clen < 64 && memByte(32'h100 + k*32'h40 + clen) != 8'hEE) bad++;
      // R4 R10: buffer contents, pad, payload, CRC and the byte after
      chk(bad == 0, "R4/R10 buffer bytes", 32'(bad), 32'h0);
    end
    if (ov) begin
      // R12: overrun drops the tail and deactivates
      chk(cntOvr == 1 && cntFrame == 0 && !rxActive, "R12 overrun",
          {cntOvr[15:0], cntFrame[7:0], 7'h0, rxActive}, 32'h0001_0000);
      if (filled < 4)
        chk(mem[2*filled] == (filled == 3 ? 32'h2000_0000 : 32'h0), "R12 full descriptor untouched",
            mem[2*filled], (filled == 3 ? 32'h2000_0000 : 32'h0));
    end else begin
      // R6: event counts
      chk(cntFrame == 1 && cntBuf == nCh - 1, "R6 events",
          {cntFrame[15:0], cntBuf[15:0]}, {16'd1, 16'(nCh - 1)});
      // R11: receive-active follows the next descriptor
      chk(rxActive == ((nCh < 4) && (nCh < nEmpty)), "R11 rxActive after frame",
          32'(rxActive), 32'((nCh < 4) && (nCh < nEmpty)));
    end
  endtask

  task automatic fillPayload(input int len);
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    setupRing(4);
    doReset();
    // R1: reset state
    chk(!rxActive && !frmReady && !memEn && !evtRxFrame && !evtRxBuf && !evtOverrun,
        "R1 reset outputs", {rxActive, frmReady, memEn, evtRxFrame, evtRxBuf, evtOverrun}, 32'h0);

    // R2: kick reads empty bit
    setupRing(0);
    kick();
    chk(rxActive == 1'b0, "R2 kick on full descriptor", 32'(rxActive), 32'h0);
    setupRing(4);
    kick();
    chk(rxActive == 1'b1, "R2 kick on empty descriptor", 32'(rxActive), 32'h1);

    // R3: frame while inactive is discarded
    doReset();
    setupRing(4);
    fillPayload(10);
    sendFrame(10);
    chk(cntWr == 0 && cntFrame == 0 && cntBuf == 0 && !rxActive, "R3 inactive frame dropped",
        32'(cntWr + cntFrame + cntBuf), 32'h0);
    chk(mem[0] == 32'h8000_0000, "R3 descriptor untouched", mem[0], 32'h8000_0000);

    // R4 R5: exact single buffer
    maxBufLen = 16; shift16En = 0; truncLimit = 2047; lenLimit = 1518;
    fillPayload(12); runFrame(12, 4);
    // R5: CRC split across two descriptors
    fillPayload(14); runFrame(14, 4);
    // R10: pad on first buffer only
    shift16En = 1;
    fillPayload(20); runFrame(20, 4);
    shift16En = 0;
    // R8: truncation
    truncLimit = 24;
    fillPayload(40); runFrame(40, 4);
    truncLimit = 2047;
    // R9: too long only
    lenLimit = 20;
    fillPayload(30); runFrame(30, 4);
    lenLimit = 1518;
    // R7: wrap through all four descriptors
    maxBufLen = 8;
    fillPayload(25); runFrame(25, 4);
    mem[0] = 32'h8000_0000;
    kick();
    chk(rxActive == 1'b1, "R7 pointer wrapped to ring base", 32'(rxActive), 32'h1);
    // R12: overrun on the second descriptor
    fillPayload(20); runFrame(20, 1);

    // random mix
    for (int t = 0; t < 24; t++) begin
      maxBufLen = 16'(8 + $urandom_range(0, 24));
      shift16En = 1'($urandom_range(0, 1));
      truncLimit = ($urandom_range(0, 3) == 0) ? 16'(20 + $urandom_range(0, 30)) : 16'd2047;
      lenLimit = 16'(16 + $urandom_range(0, 60));
      begin
        int len;
        len = $urandom_range(1, 60);
        fillPayload(len);
        runFrame(len, $urandom_range(1, 4));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule